// File: doc/BRIEF.md
# Retriggerable Relay Delay-Off Controller

This block is the digital core of a delay-off relay timer. It receives two comparator decisions that are already digital, an enable level and a window-trigger level, and a one-cycle tick from a slow external oscillator. Each input is resynchronised and then debounced by a filter that counts oscillator ticks. The enable filter always needs a long dwell. The trigger filter needs a short dwell when the relay is idle and a longer one when it tries to re-arm a relay that is still held. The two filtered levels are ANDed into a trigger condition. The relay closes while that condition holds. When the condition ends, a tracking countdown of oscillator ticks keeps the relay closed until it expires.

After the relay opens, a lockout window blocks new triggering. During that window the trigger filter is held at its off level, so transients from the load switching off cannot fire the block again. A supply-monitor reset clears every filter, counter and state flag and holds the relay open. When the reset is released, one complete hold and lockout cycle runs without any trigger, so that the whole function is visible at power-up.

The controller reports its phase on a two-bit state output next to the relay drive. All counting is synchronous to the system clock, and the oscillator tick acts as a clock enable.

Top module: `relay_hold_ctrl`

## Requirements
- R1: While rst is high, and on the first cycle after it, relay_on is 0 and state_o is 0 (idle). State codes: 0 idle, 1 active (trigger condition present), 2 hold (tracking countdown), 3 lockout.
- R2: On the first clock after rst falls, the block enters hold (state_o=2, relay_on=1) regardless of its inputs. It stays there for HOLD_TICKS (default 100) oscillator ticks and then enters lockout.
- R3: The relay can only be closed by a trigger when both the filtered enable and the filtered trigger are on. A filtered trigger alone leaves the block idle.
- R4: While the condition holds, state_o is 1. When it ends, state_o becomes 2, and the relay stays on for exactly HOLD_TICKS further ticks before it opens.
- R5: A new level on en_raw is accepted only after it has held for EN_TICKS (default 1024) ticks. This applies to both rising and falling transitions.
- R6: With the relay open, a rising trig_raw is accepted after TRIG_ON_TICKS (default 4) ticks. A falling trig_raw is always accepted after TRIG_OFF_TICKS (default 4) ticks.
- R7: While the relay is held in its countdown, a rising trig_raw is accepted only after TRIG_RE_TICKS (default 64) ticks.
- R8: A retrigger during hold returns the block to active. After the condition ends again, the full HOLD_TICKS countdown restarts.
- R9: Lockout lasts LOCK_TICKS (default 64) ticks with the relay open. trig_raw has no effect during it, and the trigger filter starts counting from zero once the block is idle again.
- R10: If a raw input returns to its accepted level before its dwell count completes, the filter count restarts, and a later transition needs the full dwell again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Supply-monitor reset, synchronous, active high |
| osc_tick | input | 1 | One-cycle pulse from the slow oscillator, used as a clock enable |
| en_raw | input | 1 | Enable comparator decision, asynchronous |
| trig_raw | input | 1 | Window-trigger comparator decision, asynchronous |
| relay_on | output | 1 | Relay drive, 1 = closed |
| state_o | output | 2 | Phase code: 0 idle, 1 active, 2 hold, 3 lockout |

## Verification
The bench counts oscillator ticks and checks each dwell one tick before and exactly at its boundary. A filter that is one count off, or that uses the short trigger delay while the relay is held, would switch a tick early or late. The bench raises the trigger during lockout and expects the block to remain idle afterwards until a fresh four-tick dwell has passed. A design that did not clear the trigger filter would close the relay the moment lockout ended. A retrigger during hold is followed by a full-length countdown, which exposes a counter that resumes instead of reloading. A short glitch on the trigger, followed by a reapplied level, shows whether the dwell count restarts or accumulates across the gap.

// File: rtl/relay_hold_pkg.sv
package relay_hold_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_HOLD   = 2'd2,
        ST_LOCK   = 2'd3
    } relay_state_e;

    typedef struct packed {
        logic en;
        logic trig;
    } in_pair_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        return max2(max2(a, b), c);
    endfunction

    function automatic logic relay_closed(input relay_state_e s);
        return (s == ST_ACTIVE) || (s == ST_HOLD);
    endfunction

endpackage

// File: rtl/in_sync.sv
module in_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta[i] <= 1'b0;
                q[i]    <= 1'b0;
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/dwell_filter.sv
module dwell_filter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          clear,
    input  logic          raw,
    input  logic [CW-1:0] limit,
    output logic          level
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            level <= 1'b0;
            cnt   <= '0;
        end else if (raw == level) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == limit - 1'b1) begin
                level <= raw;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
    import relay_hold_pkg::*;
#(
    parameter int HOLD_TICKS = 100,
    parameter int LOCK_TICKS = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         cond,
    output relay_state_e state
);
    localparam int CW = $clog2(max2(HOLD_TICKS, LOCK_TICKS) + 1);
    localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_TICKS);
    localparam logic [CW-1:0] LOCK_LD = CW'(LOCK_TICKS);

    logic [CW-1:0] remain;
    logic          boot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            remain <= '0;
            boot   <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (boot) begin
                        boot   <= 1'b0;
                        state  <= ST_HOLD;
                        remain <= HOLD_LD;
                    end else if (cond) begin
                        state <= ST_ACTIVE;
                    end
                end
                ST_ACTIVE: begin
                    if (!cond) begin
                        state  <= ST_HOLD;
                        remain <= HOLD_LD;
                    end
                end
                ST_HOLD: begin
                    if (cond) begin
                        state <= ST_ACTIVE;
                    end else if (tick) begin
                        if (remain <= 1) begin
                            state  <= ST_LOCK;
                            remain <= LOCK_LD;
                        end else begin
                            remain <= remain - 1'b1;
                        end
                    end
                end
                ST_LOCK: begin
                    if (tick) begin
                        if (remain <= 1) begin
                            state <= ST_IDLE;
                        end else begin
                            remain <= remain - 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/relay_hold_ctrl.sv
module relay_hold_ctrl
    import relay_hold_pkg::*;
#(
    parameter int EN_TICKS       = 1024,
    parameter int TRIG_ON_TICKS  = 4,
    parameter int TRIG_RE_TICKS  = 64,
    parameter int TRIG_OFF_TICKS = 4,
    parameter int HOLD_TICKS     = 100,
    parameter int LOCK_TICKS     = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       en_raw,
    input  logic       trig_raw,
    output logic       relay_on,
    output logic [1:0] state_o
);
    localparam int EW = $clog2(EN_TICKS + 1);
    localparam int TW = $clog2(max3(TRIG_ON_TICKS, TRIG_RE_TICKS, TRIG_OFF_TICKS) + 1);

    in_pair_t     raw_in;
    in_pair_t     synced;
    logic         en_f;
    logic         trig_f;
    logic [TW-1:0] trig_limit;
    relay_state_e state_q;

    assign raw_in = '{en: en_raw, trig: trig_raw};

    in_sync #(.WIDTH(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (synced)
    );

    dwell_filter #(.CW(EW)) u_en_filt (
        .clk   (clk),
        .rst   (rst),
        .tick  (osc_tick),
        .clear (1'b0),
        .raw   (synced.en),
        .limit (EW'(EN_TICKS)),
        .level (en_f)
    );

    always_comb begin
        if (trig_f)
            trig_limit = TW'(TRIG_OFF_TICKS);
        else if (relay_closed(state_q))
            trig_limit = TW'(TRIG_RE_TICKS);
        else
            trig_limit = TW'(TRIG_ON_TICKS);
    end

    dwell_filter #(.CW(TW)) u_trig_filt (
        .clk   (clk),
        .rst   (rst),
        .tick  (osc_tick),
        .clear (state_q == ST_LOCK),
        .raw   (synced.trig),
        .limit (trig_limit),
        .level (trig_f)
    );

    hold_fsm #(
        .HOLD_TICKS (HOLD_TICKS),
        .LOCK_TICKS (LOCK_TICKS)
    ) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .tick  (osc_tick),
        .cond  (en_f && trig_f),
        .state (state_q)
    );

    assign relay_on = relay_closed(state_q);
    assign state_o  = state_q;
endmodule

// File: rtl/relay_hold_chk.sv
module relay_hold_chk
    import relay_hold_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input relay_state_e state,
    input logic         en_f,
    input logic         trig_f
);
    // R3
    active_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE && $past(state) != ST_ACTIVE) |-> $past(en_f && trig_f));

    // R4
    active_exit_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_ACTIVE |=> (state == ST_ACTIVE || state == ST_HOLD));

    // R5
    en_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(en_f));

    // R9
    lock_filter_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_LOCK |=> !trig_f);

    // R9
    lock_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK && !tick) |=> state == ST_LOCK);
endmodule

bind relay_hold_ctrl relay_hold_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (osc_tick),
    .state  (state_q),
    .en_f   (en_f),
    .trig_f (trig_f)
);

// File: tb/relay_hold_ctrl_test.sv
module relay_hold_ctrl_test;
    localparam int EN_T   = 1024;
    localparam int HOLD_T = 100;
    localparam int LOCK_T = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_raw = 1'b0;
    logic       trig_raw = 1'b0;
    logic       osc_tick;
    logic       relay_on;
    logic [1:0] state_o;
    logic [1:0] divcnt = '0;
    int         tick_total = 0;
    int         tests = 0;
    int         fails = 0;

    always #2 clk = ~clk;

    assign osc_tick = (divcnt == 2'd3);
    always @(posedge clk) begin
        divcnt <= divcnt + 1'b1;
        if (osc_tick) tick_total <= tick_total + 1;
    end

    relay_hold_ctrl uut (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .en_raw   (en_raw),
        .trig_raw (trig_raw),
        .relay_on (relay_on),
        .state_o  (state_o)
    );

    task automatic wait_ticks(input int n);
        int target;
        target = tick_total + n;
        wait (tick_total == target);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic expect_st(input string req, input int exp_state, input logic exp_relay);
        tests++;
        if (state_o !== 2'(exp_state) || relay_on !== exp_relay) begin
            fails++;
            $display("FAIL %s: state=%0d relay=%0b, expected state=%0d relay=%0b",
                     req, state_o, relay_on, exp_state, exp_relay);
        end
    endtask

    task automatic reset_and_boot();
        rst = 1'b1;
        repeat (6) @(negedge clk);
        expect_st("R1 in reset", 0, 1'b0);
        wait_ticks(1);
        rst = 1'b0;
        @(negedge clk);
        expect_st("R2 forced hold after release", 2, 1'b1);
        wait_ticks(HOLD_T - 1);
        expect_st("R2 hold one tick before end", 2, 1'b1);
        wait_ticks(1);
        expect_st("R2 lockout after forced hold", 3, 1'b0);
        wait_ticks(LOCK_T - 1);
        expect_st("R9 lockout one tick before end", 3, 1'b0);
        wait_ticks(1);
        expect_st("R9 idle after lockout", 0, 1'b0);
    endtask

    task automatic enable_dwell();
        trig_raw = 1'b1;
        wait_ticks(8);
        expect_st("R3 trigger alone stays idle", 0, 1'b0);
        en_raw = 1'b1;
        wait_ticks(EN_T - 1);
        expect_st("R5 enable rise not yet accepted", 0, 1'b0);
        wait_ticks(1);
        expect_st("R5 enable rise accepted", 1, 1'b1);
        en_raw = 1'b0;
        wait_ticks(EN_T - 1);
        expect_st("R5 enable fall not yet accepted", 1, 1'b1);
        wait_ticks(1);
        expect_st("R4 hold after enable fall", 2, 1'b1);
        wait_ticks(HOLD_T - 1);
        expect_st("R4 hold length minus one", 2, 1'b1);
        wait_ticks(1);
        expect_st("R4 relay opens after hold", 3, 1'b0);
        wait_ticks(LOCK_T);
        expect_st("R9 idle again", 0, 1'b0);
        en_raw = 1'b1;
        wait_ticks(EN_T);
        expect_st("R3 both inputs on", 1, 1'b1);
    endtask

    task automatic retrigger_hold();
        trig_raw = 1'b0;
        wait_ticks(3);
        expect_st("R6 trigger fall not yet accepted", 1, 1'b1);
        wait_ticks(1);
        expect_st("R6 trigger fall after four ticks", 2, 1'b1);
        wait_ticks(10);
        trig_raw = 1'b1;
        wait_ticks(63);
        expect_st("R7 retrigger needs long dwell", 2, 1'b1);
        wait_ticks(1);
        expect_st("R7 retrigger accepted", 1, 1'b1);
        trig_raw = 1'b0;
        wait_ticks(4);
        expect_st("R8 hold entered again", 2, 1'b1);
        wait_ticks(HOLD_T - 1);
        expect_st("R8 full countdown restarted", 2, 1'b1);
        wait_ticks(1);
        expect_st("R8 lockout after restarted hold", 3, 1'b0);
    endtask

    task automatic lockout_ignore();
        trig_raw = 1'b1;
        wait_ticks(LOCK_T - 1);
        expect_st("R9 trigger ignored in lockout", 3, 1'b0);
        wait_ticks(1);
        expect_st("R9 idle despite raw trigger", 0, 1'b0);
        wait_ticks(3);
        expect_st("R9 fresh dwell not complete", 0, 1'b0);
        wait_ticks(1);
        expect_st("R6 trigger rise after four ticks", 1, 1'b1);
    endtask

    task automatic glitch_restart();
        trig_raw = 1'b0;
        wait_ticks(4 + HOLD_T + LOCK_T);
        expect_st("R10 back to idle", 0, 1'b0);
        trig_raw = 1'b1;
        wait_ticks(3);
        trig_raw = 1'b0;
        wait_ticks(2);
        expect_st("R10 short pulse rejected", 0, 1'b0);
        trig_raw = 1'b1;
        wait_ticks(3);
        expect_st("R10 count restarted", 0, 1'b0);
        wait_ticks(1);
        expect_st("R10 full dwell accepted", 1, 1'b1);
    endtask

    task automatic reset_mid_run();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        expect_st("R1 reset drops relay", 0, 1'b0);
        wait_ticks(1);
        rst = 1'b0;
        @(negedge clk);
        expect_st("R2 forced cycle after second reset", 2, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        reset_and_boot();
        enable_dwell();
        retrigger_hold();
        lockout_ignore();
        glitch_restart();
        reset_mid_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule